// File: doc/BRIEF.md
# I2C SCL Timing Generator

This block derives the serial clock waveform of an I2C bus master from the system clock. It also sequences the START and STOP conditions. A byte engine requests a message with a one-cycle `go_req` pulse. The generator then pulls SDA low while SCL is still released and holds that state for a programmable start-hold count. After that it runs a free-running alternation of SCL low and SCL high phases until the byte engine asks for a stop. Phase lengths are programmable cycle counts, typically set for a 40/60 high/low duty. Software derives them from a prescale of the source clock over four times the bus rate, minus one. With a 26 MHz source this gives rates of 100 kHz or 400 kHz.

Each of the high and low counts is `CNT_W` bits wide. Software writes them as two half-width pieces spread over two divider words. Word 0 holds the lower halves, with the high count in its upper half and the low count in its lower half. Word 1 holds the upper halves in the same arrangement. The block gives the byte engine an SCL pull-down enable and an SDA pull-down enable for the START and STOP conditions. It also gives one-cycle strobes at each SCL rise and fall, at the middle of each data low phase (the point where data may change) and at the middle of each high phase (the sample point).

All three counts are captured when a message starts. A register write made during a message therefore never disturbs a byte already in flight.

Top module: `scl_timing_gen`

## Requirements
- R1: After reset and whenever `busy` is 0, both `scl_drive_low` and `sda_drive_low` are 0 (both lines released).
- R2: The high count is {`div_word1`[CNT_W-1:CNT_W/2], `div_word0`[CNT_W-1:CNT_W/2]}. The low count is {`div_word1`[CNT_W/2-1:0], `div_word0`[CNT_W/2-1:0]}.
- R3: A `go_req` pulse while idle starts a message. In the first busy cycle `sda_drive_low`=1 and `scl_drive_low`=0. This lasts exactly start-hold cycles. Then `scl_drive_low` rises together with a one-cycle `scl_fall_stb`.
- R4: During a message SCL alternates low phases of exactly the low count and high phases of exactly the high count. `scl_fall_stb` is 1 in the first cycle of each low phase and `scl_rise_stb` is 1 in the first cycle of each high phase.
- R5: `mid_low_stb` fires in cycle floor(L/2) of a data low phase of length L, counting the first cycle as 0. `mid_high_stb` fires in cycle floor(H/2) of a high phase of length H.
- R6: A high, low or start-hold count of zero acts as a count of one cycle.
- R7: A `stop_req` pulse during a message takes effect at the end of the current high phase. SCL is then driven low for one low count with SDA low. SCL is released for one high count with SDA still low. Then SDA is released and `busy` falls.
- R8: The divider and start-hold inputs are captured at `go_req`. Changes to them during a message have no effect until the next message.
- R9: `go_req` while `busy` is 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| go_req | input | 1 | One-cycle request to begin a message (START) |
| stop_req | input | 1 | One-cycle request to end the message (STOP) |
| div_word0 | input | CNT_W | Lower halves of high count (upper field) and low count (lower field) |
| div_word1 | input | CNT_W | Upper halves of high count (upper field) and low count (lower field) |
| start_hold_cnt | input | CNT_W | Cycles between SDA falling and SCL falling at START |
| scl_drive_low | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_drive_low | output | 1 | 1 pulls SDA low for a START or STOP condition |
| busy | output | 1 | A message is in progress |
| scl_rise_stb | output | 1 | First cycle of an SCL high phase |
| scl_fall_stb | output | 1 | First cycle of an SCL low phase |
| mid_low_stb | output | 1 | Middle of a data low phase (data-change point) |
| mid_high_stb | output | 1 | Middle of a high phase (sample point) |

## Verification
The bench builds the generator with `CNT_W` = 16, so each divider word carries 8-bit fields. With that width a set bit in an upper-half field is worth 256 cycles, so the interleaved unpacking of both words can be measured directly in a short run. The default 32-bit width would put the upper halves out of reach. The same width keeps the zero-count case and the short 3/5-cycle phases cheap, so START, STOP and mid-phase strobe positions can be timed exactly.

// File: rtl/scl_timing_pkg.sv
package scl_timing_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START_HOLD,
      ST_LOW,
      ST_HIGH,
      ST_STOP_LOW,
      ST_STOP_HIGH
   } scl_state_e;
endpackage

// File: rtl/scl_div_unpack.sv
module scl_div_unpack #(
   parameter int CNT_W = 32
) (
   input  logic [CNT_W-1:0] div_word0,
   input  logic [CNT_W-1:0] div_word1,
   input  logic [CNT_W-1:0] hold_word,
   output logic [CNT_W-1:0] hi_len,
   output logic [CNT_W-1:0] lo_len,
   output logic [CNT_W-1:0] hold_len
);
   localparam int HALF = CNT_W / 2;

   logic [CNT_W-1:0] hi_raw;
   logic [CNT_W-1:0] lo_raw;

   // word g supplies half g of each count
   for (genvar g = 0; g < 2; g++) begin : g_half
      if (g == 0) begin : g_word0
         assign hi_raw[HALF-1:0] = div_word0[CNT_W-1:HALF];
         assign lo_raw[HALF-1:0] = div_word0[HALF-1:0];
      end else begin : g_word1
         assign hi_raw[CNT_W-1:HALF] = div_word1[CNT_W-1:HALF];
         assign lo_raw[CNT_W-1:HALF] = div_word1[HALF-1:0];
      end
   end

   // zero counts behave as a single cycle (R6)
   assign hi_len   = (hi_raw == '0)    ? CNT_W'(1) : hi_raw;
   assign lo_len   = (lo_raw == '0)    ? CNT_W'(1) : lo_raw;
   assign hold_len = (hold_word == '0) ? CNT_W'(1) : hold_word;
endmodule

// File: rtl/scl_phase_ctr.sv
module scl_phase_ctr #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             phase_last,
   output logic             phase_mid
);
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] mid_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= CNT_W'(1);
         mid_q <= CNT_W'(1);
      end else if (load) begin
         cnt_q <= load_val;
         // ceil(N/2) remaining cycles marks index floor(N/2)
         mid_q <= (load_val >> 1) + {{(CNT_W-1){1'b0}}, load_val[0]};
      end else if (cnt_q > CNT_W'(1)) begin
         cnt_q <= cnt_q - CNT_W'(1);
      end
   end

   assign phase_last = (cnt_q == CNT_W'(1));
   assign phase_mid  = (cnt_q == mid_q);
endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go_req,
   input  logic             stop_req,
   input  logic [CNT_W-1:0] div_word0,
   input  logic [CNT_W-1:0] div_word1,
   input  logic [CNT_W-1:0] start_hold_cnt,
   output logic             scl_drive_low,
   output logic             sda_drive_low,
   output logic             busy,
   output logic             scl_rise_stb,
   output logic             scl_fall_stb,
   output logic             mid_low_stb,
   output logic             mid_high_stb
);
   import scl_timing_pkg::*;

   if ((CNT_W % 2) != 0 || CNT_W < 4) begin : g_bad_width
      $error("scl_timing_gen: CNT_W must be even and at least 4");
   end

   scl_state_e       state_q, state_d;
   logic [CNT_W-1:0] hi_in, lo_in, hold_in;
   logic [CNT_W-1:0] hi_q, lo_q;
   logic [CNT_W-1:0] ld_val;
   logic             ld_en, ph_last, ph_mid;
   logic             stop_pend_q;
   logic             rise_d, fall_d;

   scl_div_unpack #(.CNT_W(CNT_W)) unpack_i (
      .div_word0 (div_word0),
      .div_word1 (div_word1),
      .hold_word (start_hold_cnt),
      .hi_len    (hi_in),
      .lo_len    (lo_in),
      .hold_len  (hold_in)
   );

   scl_phase_ctr #(.CNT_W(CNT_W)) ctr_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (ld_en),
      .load_val   (ld_val),
      .phase_last (ph_last),
      .phase_mid  (ph_mid)
   );

   always_comb begin
      state_d = state_q;
      ld_en   = 1'b0;
      ld_val  = lo_q;
      rise_d  = 1'b0;
      fall_d  = 1'b0;
      unique case (state_q)
         ST_IDLE: if (go_req) begin
            state_d = ST_START_HOLD;
            ld_en   = 1'b1;
            ld_val  = hold_in;
         end
         ST_START_HOLD: if (ph_last) begin
            state_d = ST_LOW;
            ld_en   = 1'b1;
            fall_d  = 1'b1;
         end
         ST_LOW: if (ph_last) begin
            state_d = ST_HIGH;
            ld_en   = 1'b1;
            ld_val  = hi_q;
            rise_d  = 1'b1;
         end
         ST_HIGH: if (ph_last) begin
            state_d = (stop_pend_q || stop_req) ? ST_STOP_LOW : ST_LOW;
            ld_en   = 1'b1;
            fall_d  = 1'b1;
         end
         ST_STOP_LOW: if (ph_last) begin
            state_d = ST_STOP_HIGH;
            ld_en   = 1'b1;
            ld_val  = hi_q;
            rise_d  = 1'b1;
         end
         ST_STOP_HIGH: if (ph_last) begin
            state_d = ST_IDLE;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q      <= ST_IDLE;
         hi_q         <= CNT_W'(1);
         lo_q         <= CNT_W'(1);
         stop_pend_q  <= 1'b0;
         scl_rise_stb <= 1'b0;
         scl_fall_stb <= 1'b0;
      end else begin
         state_q      <= state_d;
         scl_rise_stb <= rise_d;
         scl_fall_stb <= fall_d;
         // configuration is frozen for the whole message (R8)
         if (state_q == ST_IDLE && go_req) begin
            hi_q <= hi_in;
            lo_q <= lo_in;
         end
         if (state_q == ST_IDLE || state_d == ST_STOP_LOW)
            stop_pend_q <= 1'b0;
         else if (stop_req)
            stop_pend_q <= 1'b1;
      end
   end

   assign busy          = (state_q != ST_IDLE);
   assign scl_drive_low = (state_q == ST_LOW) || (state_q == ST_STOP_LOW);
   assign sda_drive_low = (state_q == ST_START_HOLD) || (state_q == ST_STOP_LOW) ||
                          (state_q == ST_STOP_HIGH);
   assign mid_low_stb   = (state_q == ST_LOW)  && ph_mid;
   assign mid_high_stb  = (state_q == ST_HIGH) && ph_mid;
endmodule

// File: rtl/scl_timing_chk.sv
module scl_timing_chk (
   input logic clk,
   input logic rst_n,
   input logic busy,
   input logic scl_drive_low,
   input logic sda_drive_low,
   input logic scl_rise_stb,
   input logic scl_fall_stb,
   input logic mid_low_stb,
   input logic mid_high_stb
);
   assert_idle_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!scl_drive_low && !sda_drive_low));

   assert_start_cond_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> (sda_drive_low && !scl_drive_low));

   assert_fall_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(scl_drive_low) |-> scl_fall_stb);

   assert_rise_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(scl_drive_low) |-> scl_rise_stb);

   assert_edge_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({scl_rise_stb, scl_fall_stb}));

   assert_mid_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
      mid_low_stb |-> scl_drive_low);

   assert_mid_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
      mid_high_stb |-> !scl_drive_low);

   assert_stop_cond_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> ($past(sda_drive_low) && !$past(scl_drive_low)));
endmodule

bind scl_timing_gen scl_timing_chk chk_i (
   .clk           (clk),
   .rst_n         (rst_n),
   .busy          (busy),
   .scl_drive_low (scl_drive_low),
   .sda_drive_low (sda_drive_low),
   .scl_rise_stb  (scl_rise_stb),
   .scl_fall_stb  (scl_fall_stb),
   .mid_low_stb   (mid_low_stb),
   .mid_high_stb  (mid_high_stb)
);

// File: tb/scl_timing_gen_tb_top.sv
module scl_timing_gen_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int CW         = 16;
   localparam int WDOG_CYC   = 100000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          go_req = 1'b0;
   logic          stop_req = 1'b0;
   logic [CW-1:0] div_word0 = '0;
   logic [CW-1:0] div_word1 = '0;
   logic [CW-1:0] start_hold_cnt = '0;
   logic scl_drive_low, sda_drive_low, busy;
   logic scl_rise_stb, scl_fall_stb, mid_low_stb, mid_high_stb;

   int cyc = 0;
   int n_run = 0;
   int n_fail = 0;
   int t_fall, t_rise, t_midlo, t_midhi;
   int n_fall = 0, n_rise = 0;
   logic sda_at_fall, sda_at_rise, scl_at_fall, scl_at_rise;

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   scl_timing_gen #(.CNT_W(CW)) dut_i (
      .clk            (clk),
      .rst_n          (rst_n),
      .go_req         (go_req),
      .stop_req       (stop_req),
      .div_word0      (div_word0),
      .div_word1      (div_word1),
      .start_hold_cnt (start_hold_cnt),
      .scl_drive_low  (scl_drive_low),
      .sda_drive_low  (sda_drive_low),
      .busy           (busy),
      .scl_rise_stb   (scl_rise_stb),
      .scl_fall_stb   (scl_fall_stb),
      .mid_low_stb    (mid_low_stb),
      .mid_high_stb   (mid_high_stb)
   );

   // event monitor, sampled away from the active edge
   always @(negedge clk) begin
      if (scl_fall_stb) begin
         t_fall = cyc; n_fall++; sda_at_fall = sda_drive_low; scl_at_fall = scl_drive_low;
      end
      if (scl_rise_stb) begin
         t_rise = cyc; n_rise++; sda_at_rise = sda_drive_low; scl_at_rise = scl_drive_low;
      end
      if (mid_low_stb)  t_midlo = cyc;
      if (mid_high_stb) t_midhi = cyc;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("[TB] FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic set_cfg(input int hi, input int lo, input int hold);
      @(negedge clk);
      div_word0      = {hi[7:0],  lo[7:0]};
      div_word1      = {hi[15:8], lo[15:8]};
      start_hold_cnt = CW'(hold);
   endtask

   task automatic wait_fall(output int t);
      int n = n_fall;
      while (n_fall == n) @(posedge clk);
      t = t_fall;
   endtask

   task automatic wait_rise(output int t);
      int n = n_rise;
      while (n_rise == n) @(posedge clk);
      t = t_rise;
   endtask

   task automatic pulse_go(output int c0);
      @(negedge clk); go_req = 1'b1;
      @(negedge clk); go_req = 1'b0;
      c0 = cyc;
   endtask

   // stop issued during a low phase; hi/lo are the effective counts
   task automatic do_stop(input int hi, input int lo);
      int tr, ts, tr2, te;
      @(negedge clk); stop_req = 1'b1;
      @(negedge clk); stop_req = 1'b0;
      wait_rise(tr);
      wait_fall(ts);
      chk(ts - tr == hi, "R7 stop low entry", ts - tr, hi);
      chk(sda_at_fall == 1'b1, "R7 sda low with scl low", sda_at_fall, 1);
      wait_rise(tr2);
      chk(tr2 - ts == lo, "R7 stop low length", tr2 - ts, lo);
      chk(sda_at_rise == 1'b1 && scl_at_rise == 1'b0, "R7 sda held while scl high", sda_at_rise, 1);
      do @(negedge clk); while (busy);
      te = cyc;
      chk(te - tr2 == hi, "R7 sda release delay", te - tr2, hi);
      chk(!scl_drive_low && !sda_drive_low, "R1 released after stop",
          {scl_drive_low, sda_drive_low}, 0);
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk(!busy && !scl_drive_low && !sda_drive_low, "R1 reset idle",
          {busy, scl_drive_low, sda_drive_low}, 0);
      chk(!scl_rise_stb && !scl_fall_stb && !mid_low_stb && !mid_high_stb, "R1 reset strobes",
          {scl_rise_stb, scl_fall_stb, mid_low_stb, mid_high_stb}, 0);
   endtask

   task automatic t_start_and_phases();
      int c0, tf, tr, tf2;
      set_cfg(3, 5, 4);
      pulse_go(c0);
      chk(busy && sda_drive_low && !scl_drive_low, "R3 start condition",
          {busy, sda_drive_low, scl_drive_low}, 6);
      wait_fall(tf);
      chk(tf - c0 == 4, "R3 start hold", tf - c0, 4);
      chk(scl_at_fall && !sda_at_fall, "R3 scl low sda released", {scl_at_fall, sda_at_fall}, 2);
      wait_rise(tr);
      chk(tr - tf == 5, "R4 low phase", tr - tf, 5);
      chk(t_midlo - tf == 2, "R5 mid low point", t_midlo - tf, 2);
      wait_fall(tf2);
      chk(tf2 - tr == 3, "R4 high phase", tf2 - tr, 3);
      chk(t_midhi - tr == 1, "R5 mid high point", t_midhi - tr, 1);
      do_stop(3, 5);
   endtask

   task automatic t_split_words();
      int c0, tf, tr, tf2;
      set_cfg(16'h0102, 16'h0100, 2);
      pulse_go(c0);
      wait_fall(tf);
      chk(tf - c0 == 2, "R3 start hold short", tf - c0, 2);
      wait_rise(tr);
      chk(tr - tf == 256, "R2 low count from both words", tr - tf, 256);
      wait_fall(tf2);
      chk(tf2 - tr == 258, "R2 high count from both words", tf2 - tr, 258);
      do_stop(258, 256);
   endtask

   task automatic t_zero_counts();
      int c0, tf, tr, tf2;
      set_cfg(0, 0, 0);
      pulse_go(c0);
      wait_fall(tf);
      chk(tf - c0 == 1, "R6 zero hold", tf - c0, 1);
      wait_rise(tr);
      chk(tr - tf == 1, "R6 zero low", tr - tf, 1);
      wait_fall(tf2);
      chk(tf2 - tr == 1, "R6 zero high", tf2 - tr, 1);
      @(negedge clk); stop_req = 1'b1;
      @(negedge clk); stop_req = 1'b0;
      repeat (8) @(negedge clk);
      chk(!busy && !scl_drive_low && !sda_drive_low, "R7 stop with unit phases",
          {busy, scl_drive_low, sda_drive_low}, 0);
   endtask

   task automatic t_latch();
      int c0, tf, tr, tf2;
      set_cfg(3, 5, 2);
      pulse_go(c0);
      wait_fall(tf);
      set_cfg(7, 9, 6);
      wait_rise(tr);
      chk(tr - tf == 5, "R8 low unchanged mid-message", tr - tf, 5);
      wait_fall(tf2);
      chk(tf2 - tr == 3, "R8 high unchanged mid-message", tf2 - tr, 3);
      do_stop(3, 5);
      pulse_go(c0);
      wait_fall(tf);
      chk(tf - c0 == 6, "R8 new hold next message", tf - c0, 6);
      wait_rise(tr);
      chk(tr - tf == 9, "R8 new low next message", tr - tf, 9);
      wait_fall(tf2);
      chk(tf2 - tr == 7, "R8 new high next message", tf2 - tr, 7);
      do_stop(7, 9);
   endtask

   task automatic t_go_busy();
      int c0, tf, tr, tf2;
      set_cfg(3, 5, 2);
      pulse_go(c0);
      wait_fall(tf);
      @(negedge clk); go_req = 1'b1;
      @(negedge clk); go_req = 1'b0;
      chk(scl_drive_low && !sda_drive_low, "R9 go while busy ignored",
          {scl_drive_low, sda_drive_low}, 2);
      wait_rise(tr);
      chk(tr - tf == 5, "R9 low phase undisturbed", tr - tf, 5);
      wait_fall(tf2);
      chk(tf2 - tr == 3, "R9 high phase undisturbed", tf2 - tr, 3);
      do_stop(3, 5);
   endtask

   initial begin
      fork
         begin
            repeat (4) @(negedge clk);
            rst_n = 1'b1;
            t_reset();
            t_start_and_phases();
            t_split_words();
            t_zero_counts();
            t_latch();
            t_go_busy();
         end
         begin
            while (cyc < WDOG_CYC) @(posedge clk);
            n_run++;
            n_fail++;
            $display("[TB] FAIL watchdog: actual %0d expected %0d", cyc, 0);
         end
      join_any
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule